// File: doc/BRIEF.md
# Buck Regulator Fault Protection Arbiter

This block watches the digital fault flags of a synchronous buck controller and decides how the power stage must react. It takes five fault sources: supply lockout, a per-cycle current-limit event, a relative overvoltage flag (output about 14% above target), an absolute overvoltage flag (output above a fixed ceiling) and over-temperature. It also takes two start-up qualifiers: soft-start finished and delayed power-good. Each class has its own arming rule, its own latch policy and its own combined response. The response is an override of the top and bottom gate commands plus a mode for the soft-start pin.

Thermal and both overvoltage classes are latched. Once captured they persist until the supply passes through lockout or the enable input is removed. Current limit is not latched. It trips only after a run of consecutive limited switching cycles and drops out on the first clean cycle. With no fault present, the PWM gate requests pass straight through. A status output reports which latched class was captured first after the last clear. All outputs are registered, so each reflects the inputs sampled on the previous rising clock edge.

Top module: `fault_protect_mgr`

## Requirements
- R1: While `uvlo` is high or `en` is low, one cycle later both gates are low, `ss_ctl` is 1 (pull low) and `active_code` is 1 (lockout), whatever the other inputs are.
- R2: While `rst` is high, one cycle later both gates are low, `ss_ctl` is 1, `active_code` is 1 and `first_code` is 0, and all latched and counted state is cleared.
- R3: Current limit trips once `ilim_evt` has been high on RUN_LEN (default 32) consecutive `cyc_tick` cycles, and not after RUN_LEN-1. While tripped, the top gate is low, the bottom gate follows `pwm_lo_req`, `ss_ctl` is 2 (sawtooth) and `active_code` is 5.
- R4: The current-limit run restarts from zero on any `cyc_tick` with `ilim_evt` low. Cycles without `cyc_tick` leave the run unchanged.
- R5: Thermal shutdown is always armed and latched. Its response is both gates low, `ss_ctl` 3 (drive high) and `active_code` 2.
- R6: The absolute overvoltage fault is always armed and latched. Its response is top gate low, bottom gate high, `ss_ctl` 3 and `active_code` 3.
- R7: The relative overvoltage flag is ignored unless `ss_done` and `pgood_dly` are both high. When armed, it latches with the R6 gate and pin response and `active_code` 4.
- R8: With several classes active, `active_code` follows the order lockout, thermal, absolute OVP, relative OVP, current limit. Any overvoltage forces bottom gate high, even with thermal active, except under lockout. Both gates are never high together.
- R9: Latched faults persist after their flags and arming qualifiers fall. They clear only through `uvlo` high, `en` low or reset.
- R10: `first_code` reports the first latched class captured since the last clear (1 thermal, 2 absolute OVP, 3 relative OVP, 0 none). It holds until a clear. A tie in one cycle resolves in thermal, absolute, relative order.
- R11: With no fault active, `hi_gate` and `lo_gate` equal `pwm_hi_req` and `pwm_lo_req` one cycle later, `ss_ctl` is 0 (release) and `active_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Controller enable; low clears latched faults |
| uvlo | input | 1 | Supply undervoltage lockout flag |
| cyc_tick | input | 1 | One-cycle strobe marking the end of a switching cycle |
| ilim_evt | input | 1 | Current limit hit during the cycle ending at `cyc_tick` |
| ovp_rel | input | 1 | Output above the relative overvoltage threshold |
| ovp_abs | input | 1 | Output above the absolute overvoltage ceiling |
| ot_flag | input | 1 | Over-temperature flag |
| ss_done | input | 1 | Soft-start has finished |
| pgood_dly | input | 1 | Delayed power-good is asserted |
| pwm_hi_req | input | 1 | Top gate request from the PWM loop |
| pwm_lo_req | input | 1 | Bottom gate request from the PWM loop |
| hi_gate | output | 1 | Top gate command |
| lo_gate | output | 1 | Bottom gate command |
| ss_ctl | output | 2 | Soft-start pin mode: 0 release, 1 pull low, 2 sawtooth, 3 drive high |
| active_code | output | 3 | Winning fault: 0 none, 1 lockout, 2 thermal, 3 abs OVP, 4 rel OVP, 5 current limit |
| first_code | output | 2 | First latched class since clear: 0 none, 1 thermal, 2 abs OVP, 3 rel OVP |

## Verification
The no-shoot-through assertion relies on the PWM loop never requesting both gates in the same cycle, because the pass-through path forwards those requests unchanged. The bench draws gate requests only from the three legal combinations. The counter assertions treat `cyc_tick` as a strobe synchronous to `clk`, and the random stimulus produces it that way. Fault flags are drawn rarely and in bursts, so that long limited runs, late-armed overvoltage and overlapping classes all occur between lockout and enable clears.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [1:0] {
    SS_RELEASE    = 2'd0,
    SS_PULL_LOW   = 2'd1,
    SS_SAWTOOTH   = 2'd2,
    SS_DRIVE_HIGH = 2'd3
  } ss_ctl_e;

  typedef enum logic [2:0] {
    FC_NONE     = 3'd0,
    FC_LOCKOUT  = 3'd1,
    FC_THERMAL  = 3'd2,
    FC_OVP_ABS  = 3'd3,
    FC_OVP_REL  = 3'd4,
    FC_ILIM     = 3'd5
  } fault_code_e;

  // latched class slots, index order is capture priority
  localparam int LAT_THERMAL = 0;
  localparam int LAT_OVP_ABS = 1;
  localparam int LAT_OVP_REL = 2;
  localparam int NUM_LATCHED = 3;
  localparam int FIRST_W     = $clog2(NUM_LATCHED + 1);

  typedef struct packed {
    logic        hi;
    logic        lo;
    ss_ctl_e     ss;
    fault_code_e code;
  } drive_cmd_t;

endpackage

// File: rtl/fpm_ilim_counter.sv
module fpm_ilim_counter #(
  parameter int RUN_LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic cyc_tick,
  input  logic ilim_evt,
  output logic trip
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (cyc_tick) begin
      if (!ilim_evt)
        cnt_q <= '0;
      else if (cnt_q != CNT_MAX)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign trip = (cnt_q == CNT_MAX);

  AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX); // R3

  AST_CNT_GAP_RESTART: assert property (@(posedge clk) disable iff (rst)
    (cyc_tick && !ilim_evt) |=> (cnt_q == '0)); // R4

  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cyc_tick && !clr) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/fpm_fault_latch.sv
module fpm_fault_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set_req,
  output logic [N-1:0] eff,
  output logic [N-1:0] held
);
  logic [N-1:0] held_q;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign eff[i] = !clr && (held_q[i] || set_req[i]);

    always_ff @(posedge clk) begin
      if (rst) held_q[i] <= 1'b0;
      else     held_q[i] <= eff[i];
    end

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (held_q[i] && !clr) |=> held_q[i]); // R9

    AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
      clr |=> !held_q[i]); // R9
  end

  assign held = held_q;

endmodule

// File: rtl/fpm_first_capture.sv
module fpm_first_capture #(
  parameter int N       = 3,
  parameter int FIRST_W = $clog2(N + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [N-1:0]       eff,
  output logic [FIRST_W-1:0] first
);
  logic [FIRST_W-1:0] first_q;
  logic [FIRST_W-1:0] enc;

  // lowest index wins a same-cycle tie
  always_comb begin
    enc = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eff[i]) enc = FIRST_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      first_q <= '0;
    else if (first_q == '0)
      first_q <= enc;
  end

  assign first = first_q;

  AST_FIRST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (first_q != '0 && !clr) |=> $stable(first_q)); // R10

  AST_FIRST_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (first_q == '0)); // R10

endmodule

// File: rtl/fpm_response_mux.sv
module fpm_response_mux
  import fpm_pkg::*;
(
  input  logic                   clr,
  input  logic [NUM_LATCHED-1:0] eff,
  input  logic                   ilim_trip,
  input  logic                   pwm_hi_req,
  input  logic                   pwm_lo_req,
  output drive_cmd_t             cmd
);
  logic any_ovp;

  assign any_ovp = eff[LAT_OVP_ABS] || eff[LAT_OVP_REL];

  always_comb begin
    cmd.hi = pwm_hi_req;
    cmd.lo = pwm_lo_req;
    cmd.ss = SS_RELEASE;
    cmd.code = FC_NONE;
    if (clr) begin
      cmd.hi = 1'b0;
      cmd.lo = 1'b0;
      cmd.ss = SS_PULL_LOW;
      cmd.code = FC_LOCKOUT;
    end else if (any_ovp) begin
      // overvoltage crowbar beats all-off, code still follows priority
      cmd.hi = 1'b0;
      cmd.lo = 1'b1;
      cmd.ss = SS_DRIVE_HIGH;
      if (eff[LAT_THERMAL])      cmd.code = FC_THERMAL;
      else if (eff[LAT_OVP_ABS]) cmd.code = FC_OVP_ABS;
      else                       cmd.code = FC_OVP_REL;
    end else if (eff[LAT_THERMAL]) begin
      cmd.hi = 1'b0;
      cmd.lo = 1'b0;
      cmd.ss = SS_DRIVE_HIGH;
      cmd.code = FC_THERMAL;
    end else if (ilim_trip) begin
      cmd.hi = 1'b0;
      cmd.ss = SS_SAWTOOTH;
      cmd.code = FC_ILIM;
    end
  end

endmodule

// File: rtl/fault_protect_mgr.sv
module fault_protect_mgr
  import fpm_pkg::*;
#(
  parameter int RUN_LEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               uvlo,
  input  logic               cyc_tick,
  input  logic               ilim_evt,
  input  logic               ovp_rel,
  input  logic               ovp_abs,
  input  logic               ot_flag,
  input  logic               ss_done,
  input  logic               pgood_dly,
  input  logic               pwm_hi_req,
  input  logic               pwm_lo_req,
  output logic               hi_gate,
  output logic               lo_gate,
  output logic [1:0]         ss_ctl,
  output logic [2:0]         active_code,
  output logic [FIRST_W-1:0] first_code
);
  logic                   clr;
  logic                   ilim_trip;
  logic [NUM_LATCHED-1:0] set_req;
  logic [NUM_LATCHED-1:0] eff;
  logic [NUM_LATCHED-1:0] held;
  drive_cmd_t             cmd_d;
  drive_cmd_t             cmd_q;

  assign clr = uvlo || !en;

  // arming: relative OVP waits for the start-up qualifiers
  assign set_req[LAT_THERMAL] = ot_flag;
  assign set_req[LAT_OVP_ABS] = ovp_abs;
  assign set_req[LAT_OVP_REL] = ovp_rel && ss_done && pgood_dly;

  fpm_ilim_counter #(.RUN_LEN(RUN_LEN)) u_ilim (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .cyc_tick (cyc_tick),
    .ilim_evt (ilim_evt),
    .trip     (ilim_trip)
  );

  fpm_fault_latch #(.N(NUM_LATCHED)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .set_req (set_req),
    .eff     (eff),
    .held    (held)
  );

  fpm_first_capture #(.N(NUM_LATCHED), .FIRST_W(FIRST_W)) u_first (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .eff   (eff),
    .first (first_code)
  );

  fpm_response_mux u_mux (
    .clr        (clr),
    .eff        (eff),
    .ilim_trip  (ilim_trip),
    .pwm_hi_req (pwm_hi_req),
    .pwm_lo_req (pwm_lo_req),
    .cmd        (cmd_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q.hi   <= 1'b0;
      cmd_q.lo   <= 1'b0;
      cmd_q.ss   <= SS_PULL_LOW;
      cmd_q.code <= FC_LOCKOUT;
    end else begin
      cmd_q <= cmd_d;
    end
  end

  assign hi_gate     = cmd_q.hi;
  assign lo_gate     = cmd_q.lo;
  assign ss_ctl      = cmd_q.ss;
  assign active_code = cmd_q.code;

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !(hi_gate && lo_gate)); // R8

  AST_LOCKOUT_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    (uvlo || !en) |=> (!hi_gate && !lo_gate && ss_ctl == SS_PULL_LOW)); // R1

  AST_ABS_OVP_CROWBAR: assert property (@(posedge clk) disable iff (rst)
    (ovp_abs && en && !uvlo) |=> (lo_gate && !hi_gate)); // R6

  AST_HELD_OVP_CROWBAR: assert property (@(posedge clk) disable iff (rst)
    ((held[LAT_OVP_ABS] || held[LAT_OVP_REL]) && en && !uvlo) |=> lo_gate); // R9

endmodule

// File: tb/fault_protect_mgr_tb.sv
module fault_protect_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LEN    = 32;
  localparam int WD_CYCLES  = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, uvlo = 1'b0, cyc_tick = 1'b0, ilim_evt = 1'b0;
  logic ovp_rel = 1'b0, ovp_abs = 1'b0, ot_flag = 1'b0, ss_done = 1'b0, pgood_dly = 1'b0;
  logic pwm_hi_req = 1'b0, pwm_lo_req = 1'b0;
  logic hi_gate, lo_gate;
  logic [1:0] ss_ctl;
  logic [2:0] active_code;
  logic [1:0] first_code;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model state
  int m_cnt = 0;
  bit m_th = 0, m_ab = 0, m_re = 0;
  int m_first = 0;
  bit e_hi, e_lo;
  int e_ss, e_code, e_first;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_protect_mgr #(.RUN_LEN(RUN_LEN)) u_dut (
    .clk(clk), .rst(rst), .en(en), .uvlo(uvlo), .cyc_tick(cyc_tick),
    .ilim_evt(ilim_evt), .ovp_rel(ovp_rel), .ovp_abs(ovp_abs), .ot_flag(ot_flag),
    .ss_done(ss_done), .pgood_dly(pgood_dly), .pwm_hi_req(pwm_hi_req),
    .pwm_lo_req(pwm_lo_req), .hi_gate(hi_gate), .lo_gate(lo_gate),
    .ss_ctl(ss_ctl), .active_code(active_code), .first_code(first_code)
  );

  function automatic string code_req(int c);
    case (c)
      1: return "R1";  2: return "R5";  3: return "R6";
      4: return "R7";  5: return "R3";  default: return "R11";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // apply current inputs for one clock, then compare at the following negedge
  task automatic step(string tag);
    bit clr, th, ab, re, trip, multi;
    string rq;
    clr  = rst || uvlo || !en;
    th   = !clr && (m_th || ot_flag);
    ab   = !clr && (m_ab || ovp_abs);
    re   = !clr && (m_re || (ovp_rel && ss_done && pgood_dly));
    trip = (m_cnt == RUN_LEN);
    if (clr) begin
      e_hi = 0; e_lo = 0; e_ss = 1; e_code = 1;
    end else if (ab || re) begin
      e_hi = 0; e_lo = 1; e_ss = 3; e_code = th ? 2 : (ab ? 3 : 4);
    end else if (th) begin
      e_hi = 0; e_lo = 0; e_ss = 3; e_code = 2;
    end else if (trip) begin
      e_hi = 0; e_lo = pwm_lo_req; e_ss = 2; e_code = 5;
    end else begin
      e_hi = pwm_hi_req; e_lo = pwm_lo_req; e_ss = 0; e_code = 0;
    end
    multi = (int'(th) + int'(ab) + int'(re) + int'(trip)) > 1;
    if (clr) m_first = 0;
    else if (m_first == 0) m_first = th ? 1 : (ab ? 2 : (re ? 3 : 0));
    m_th = th; m_ab = ab; m_re = re;
    if (clr) m_cnt = 0;
    else if (cyc_tick) m_cnt = !ilim_evt ? 0 : (m_cnt < RUN_LEN ? m_cnt + 1 : m_cnt);
    e_first = m_first;
    @(posedge clk);
    @(negedge clk);
    rq = rst ? "R2" : (multi ? "R8" : code_req(e_code));
    check({rq, "/", tag}, "hi_gate", int'(hi_gate), int'(e_hi));
    check({rq, "/", tag}, "lo_gate", int'(lo_gate), int'(e_lo));
    check({rq, "/", tag}, "ss_ctl", int'(ss_ctl), e_ss);
    check({rq, "/", tag}, "active_code", int'(active_code), e_code);
    check({"R10/", tag}, "first_code", int'(first_code), e_first);
  endtask

  task automatic idle_faults();
    cyc_tick = 0; ilim_evt = 0; ovp_rel = 0; ovp_abs = 0; ot_flag = 0;
  endtask

  task automatic rand_pwm();
    int r;
    r = $urandom_range(0, 2);
    pwm_hi_req = (r == 1);
    pwm_lo_req = (r == 2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // reset state
    rst = 1; en = 1; ot_flag = 1; pwm_hi_req = 1;
    repeat (3) step("R2 reset");
    rst = 0; ot_flag = 0; pwm_hi_req = 0;
    // plain pass-through
    for (int i = 0; i < 20; i++) begin rand_pwm(); step("R11 pass"); end
    // current limit: RUN_LEN-1 limited ticks do not trip
    for (int i = 0; i < RUN_LEN - 1; i++) begin
      rand_pwm(); cyc_tick = 1; ilim_evt = 1; step("R3 run");
      cyc_tick = 0; step("R4 idle");
    end
    check("R3", "no trip at RUN_LEN-1", int'(ss_ctl), 0);
    cyc_tick = 1; ilim_evt = 0; step("R4 gap");
    for (int i = 0; i < RUN_LEN; i++) begin
      rand_pwm(); cyc_tick = 1; ilim_evt = 1; step("R3 run");
      cyc_tick = 0; step("R4 idle");
    end
    check("R3", "sawtooth after RUN_LEN", int'(ss_ctl), 2);
    check("R3", "top gate low in limit", int'(hi_gate), 0);
    ilim_evt = 0; repeat (5) begin rand_pwm(); step("R4 no tick holds"); end
    check("R4", "still tripped without tick", int'(active_code), 5);
    cyc_tick = 1; step("R4 clean tick"); cyc_tick = 0; step("R4 released");
    check("R4", "released after clean tick", int'(active_code), 0);
    // relative OVP unarmed then armed
    ss_done = 0; pgood_dly = 1; ovp_rel = 1; step("R7 unarmed");
    ovp_rel = 0; step("R7 unarmed gone");
    check("R7", "unarmed rel ovp ignored", int'(active_code), 0);
    ss_done = 1; ovp_rel = 1; step("R7 armed"); ovp_rel = 0; ss_done = 0; pgood_dly = 0;
    repeat (4) begin rand_pwm(); step("R9 persists"); end
    check("R9", "rel ovp held after qualifiers drop", int'(active_code), 4);
    check("R10", "first is rel", int'(first_code), 3);
    ot_flag = 1; step("R8 thermal over ovp"); ot_flag = 0; step("R8 hold");
    check("R8", "thermal code with ovp crowbar", int'(active_code), 2);
    check("R8", "bottom gate high despite thermal", int'(lo_gate), 1);
    check("R10", "first stays rel", int'(first_code), 3);
    en = 0; step("R9 clear by en"); en = 1; step("R9 after clear");
    check("R9", "cleared by enable drop", int'(active_code), 0);
    // simultaneous thermal and abs, clear through lockout
    ot_flag = 1; ovp_abs = 1; step("R10 tie"); idle_faults(); step("R6 held");
    check("R10", "tie resolves to thermal", int'(first_code), 1);
    ovp_abs = 1; ot_flag = 0; uvlo = 1; step("R1 lockout masks"); ovp_abs = 0; step("R1");
    check("R1", "lockout pulls ss low", int'(ss_ctl), 1);
    uvlo = 0; step("R9 after uvlo");
    check("R9", "cleared by lockout", int'(first_code), 0);
    ovp_abs = 1; step("R6 abs"); ovp_abs = 0; step("R6 held");
    check("R6", "abs ovp crowbar", int'(lo_gate), 1);
    en = 0; step("R1"); en = 1;
    // random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      rand_pwm();
      r = $urandom_range(0, 999);
      cyc_tick = ($urandom_range(0, 3) == 0);
      ilim_evt = ($urandom_range(0, 99) < 97);
      ot_flag  = (r < 2);
      ovp_abs  = (r >= 2 && r < 4);
      ovp_rel  = (r >= 4 && r < 12);
      ss_done  = ($urandom_range(0, 3) != 0);
      pgood_dly = ($urandom_range(0, 3) != 0);
      uvlo = ($urandom_range(0, 299) == 0);
      en   = ($urandom_range(0, 299) != 0);
      step("R8 random");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule